// File: doc/BRIEF.md
# Wide-Word Remote Memory Access Controller

This controller lets a 16-bit host read and write single 40-bit words held in a remote memory. The host presents a 20-bit remote address as two 16-bit words and the data as three 16-bit words. It then pulses `start` with a 3-bit opcode. The controller runs the remote bus strobes and waits for the remote side to answer. It checks the parity of returned data and aborts any access that takes too long. At the end it pulses `done` with an error code made of OR-able flags.

Three operations are carried out: fetch, store, and read-modify-write. A read-modify-write ORs the host word into the remote word. It writes the merged value back and also returns it to the host. Opcodes 3 to 7 belong to a separate block sequencer, and this block reports them as not implemented. If the remote interface already reports busy, the request is refused at once. A separate reject path covers this case and no remote cycle is started.

Top module: `rmac_top`

## Requirements
- R1: The remote address on `rm_addr` is `{addr_hi, addr_lo[15:12]}`. Bits 11:0 of `addr_lo` have no effect.
- R2: The 40-bit word is packed from the three host words as follows. `wd0` goes to bits 39:24 and `wd1` to bits 23:8. `wd2[15:8]` goes to bits 7:0, and `wd2[7:0]` is ignored. The read-back words use the same layout, and `rd2[7:0]` reads as zero.
- R3: Opcode 0 (fetch) produces exactly one `rm_fetch` strobe and no write. The returned word appears on `rd0..rd2`, with error code 0.
- R4: Opcode 1 (store) produces `rm_store` together with `rm_wvalid` carrying the packed host word. It finishes after `rm_wdone` with error code 0.
- R5: Opcode 2 (read-modify-write) raises `rm_fetch` and `rm_store` in the same cycle. It then writes back `remote | host` with one `rm_wvalid` strobe and returns that merged word to the host.
- R6: Returned data must have odd parity over `{rm_rdata, rm_rpar}`. Even parity sets error bit 0 (value 1), and the fetched word is still returned.
- R7: A parity error during read-modify-write sets bit 0, and the merged write-back is still performed.
- R8: When `rm_busy` is high at a `start`, the controller finishes in the next cycle with error bit 2 (value 4). It issues no remote strobe.
- R9: Opcodes 3 to 7 finish in the next cycle with error bit 3 (value 8) and no remote strobe. When `rm_busy` is also high, the code is 12.
- R10: If the remote side has not answered after `TIMEOUT_CYC` wait cycles, the controller sets error bit 1 (value 2) and pulses `rm_reset` alone. `done` follows between `TIMEOUT_CYC` and `TIMEOUT_CYC+6` cycles after `start`.
- R11: A timeout during the read phase issues one dummy `rm_fetch` strobe before `rm_reset`. A timeout while waiting for a write issues none.
- R12: `busy` is high from acceptance up to and including the single-cycle `done` pulse. `err_code` holds its value after `done`. A `start` while `busy` is high is ignored.
- R13: After reset, `busy`, `done`, `err_code`, the read-back words and all remote strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Request pulse, sampled while idle |
| opcode | input | 3 | 0 fetch, 1 store, 2 read-modify-write, 3-7 not handled here |
| addr_hi | input | 16 | Remote address bits 19:4 |
| addr_lo | input | 16 | Upper 4 bits are remote address bits 3:0 |
| wd0 | input | 16 | Host data, word bits 39:24 |
| wd1 | input | 16 | Host data, word bits 23:8 |
| wd2 | input | 16 | Upper byte is word bits 7:0 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 4 | OR of flags: 1 parity, 2 timeout, 4 interface busy, 8 unimplemented |
| rd0 | output | 16 | Result word bits 39:24 |
| rd1 | output | 16 | Result word bits 23:8 |
| rd2 | output | 16 | Result word bits 7:0 in the upper byte, lower byte zero |
| rm_addr | output | 20 | Remote word address |
| rm_fetch | output | 1 | Fetch start strobe |
| rm_store | output | 1 | Store start strobe |
| rm_wvalid | output | 1 | Write data valid strobe |
| rm_wdata | output | 40 | Write data |
| rm_reset | output | 1 | Remote interface reset strobe |
| rm_busy | input | 1 | Remote interface reports busy |
| rm_rvalid | input | 1 | Read data valid |
| rm_rdata | input | 40 | Read data |
| rm_rpar | input | 1 | Parity bit that goes with read data |
| rm_wdone | input | 1 | Write completed |

## Verification
The hardest situation to reach is a read-modify-write that stalls in its read phase. The controller must then set the timeout flag and issue a dummy fetch strobe, then the reset strobe. It must also leave the remote word untouched. The bench reaches this through its remote-memory model, which can be told to withhold its answer for one vector. The bench counts fetch, write and reset strobes and checks the strobe order and the remote word afterwards. In another vector the model flips the parity line under a read-modify-write. This confirms that the write-back still lands while the parity flag is raised.

// File: rtl/rmac_pkg.sv
package rmac_pkg;

  localparam logic [2:0] OP_FETCH = 3'd0;
  localparam logic [2:0] OP_STORE = 3'd1;
  localparam logic [2:0] OP_RMW   = 3'd2;

  localparam int ERR_PAR   = 0;
  localparam int ERR_TMO   = 1;
  localparam int ERR_BUSY  = 2;
  localparam int ERR_UNIMP = 3;
  localparam int ERR_W     = 4;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ISSUE   = 3'd1,
    ST_WAIT_RD = 3'd2,
    ST_WB      = 3'd3,
    ST_WAIT_WR = 3'd4,
    ST_ABORT_F = 3'd5,
    ST_ABORT_R = 3'd6,
    ST_FINISH  = 3'd7
  } ctl_st_t;

endpackage

// File: rtl/rmac_tmo.sv
module rmac_tmo #(
  parameter int unsigned CYC = 16000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                   cnt_d = CW'(CYC);
    else if (run && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/rmac_par.sv
module rmac_par #(
  parameter int W = 40
) (
  input  logic [W-1:0] data,
  input  logic         par,
  output logic         err
);
  // odd parity over data plus parity line
  assign err = ~(^{data, par});
endmodule

// File: rtl/rmac_fsm.sv
module rmac_fsm
  import rmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        opcode,
  input  logic              rm_busy,
  input  logic              rm_rvalid,
  input  logic              rm_wdone,
  input  logic              tmo_expired,
  input  logic              par_err,
  output ctl_st_t           st_o,
  output logic [2:0]        op_o,
  output logic              accept_o,
  output logic              rd_take_o,
  output logic [ERR_W-1:0]  err_o
);
  ctl_st_t          st_q, st_d;
  logic [2:0]       op_q, op_d;
  logic [ERR_W-1:0] err_q, err_d;

  always_comb begin
    st_d      = st_q;
    op_d      = op_q;
    err_d     = err_q;
    accept_o  = 1'b0;
    rd_take_o = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          err_d = '0;
          if (rm_busy || (opcode > OP_RMW)) begin
            err_d[ERR_BUSY]  = rm_busy;
            err_d[ERR_UNIMP] = (opcode > OP_RMW);
            st_d = ST_FINISH;
          end else begin
            op_d     = opcode;
            accept_o = 1'b1;
            st_d     = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: st_d = (op_q == OP_STORE) ? ST_WAIT_WR : ST_WAIT_RD;
      ST_WAIT_RD: begin
        if (rm_rvalid) begin
          rd_take_o = 1'b1;
          if (par_err) err_d[ERR_PAR] = 1'b1;
          st_d = (op_q == OP_RMW) ? ST_WB : ST_FINISH;
        end else if (tmo_expired) begin
          err_d[ERR_TMO] = 1'b1;
          st_d = ST_ABORT_F;
        end
      end
      ST_WB: st_d = ST_WAIT_WR;
      ST_WAIT_WR: begin
        if (rm_wdone) begin
          st_d = ST_FINISH;
        end else if (tmo_expired) begin
          err_d[ERR_TMO] = 1'b1;
          st_d = ST_ABORT_R;
        end
      end
      ST_ABORT_F: st_d = ST_ABORT_R;
      ST_ABORT_R: st_d = ST_FINISH;
      ST_FINISH:  st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      op_q  <= OP_FETCH;
      err_q <= '0;
    end else begin
      st_q  <= st_d;
      op_q  <= op_d;
      err_q <= err_d;
    end
  end

  assign st_o  = st_q;
  assign op_o  = op_q;
  assign err_o = err_q;
endmodule

// File: rtl/rmac_top.sv
module rmac_top
  import rmac_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 16000,
  parameter int          HOST_W      = 16,
  parameter int          LO_BITS     = 4,
  parameter int          DATA_W      = 40
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [2:0]                opcode,
  input  logic [HOST_W-1:0]         addr_hi,
  input  logic [HOST_W-1:0]         addr_lo,
  input  logic [HOST_W-1:0]         wd0,
  input  logic [HOST_W-1:0]         wd1,
  input  logic [HOST_W-1:0]         wd2,
  output logic                      busy,
  output logic                      done,
  output logic [3:0]                err_code,
  output logic [HOST_W-1:0]         rd0,
  output logic [HOST_W-1:0]         rd1,
  output logic [HOST_W-1:0]         rd2,
  output logic [HOST_W+LO_BITS-1:0] rm_addr,
  output logic                      rm_fetch,
  output logic                      rm_store,
  output logic                      rm_wvalid,
  output logic [DATA_W-1:0]         rm_wdata,
  output logic                      rm_reset,
  input  logic                      rm_busy,
  input  logic                      rm_rvalid,
  input  logic [DATA_W-1:0]         rm_rdata,
  input  logic                      rm_rpar,
  input  logic                      rm_wdone
);
  localparam int ADDR_W = HOST_W + LO_BITS;
  localparam int TAIL_W = DATA_W - 2 * HOST_W;
  localparam int PAD_W  = HOST_W - TAIL_W;

  ctl_st_t           st;
  logic [2:0]        op;
  logic              accept, rd_take, tmo_expired, par_err, tmo_run;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] word_q, word_d;

  rmac_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .opcode     (opcode),
    .rm_busy    (rm_busy),
    .rm_rvalid  (rm_rvalid),
    .rm_wdone   (rm_wdone),
    .tmo_expired(tmo_expired),
    .par_err    (par_err),
    .st_o       (st),
    .op_o       (op),
    .accept_o   (accept),
    .rd_take_o  (rd_take),
    .err_o      (err_code)
  );

  assign tmo_run = (st == ST_WAIT_RD) || (st == ST_WAIT_WR);

  rmac_tmo #(.CYC(TIMEOUT_CYC)) u_tmo (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .run    (tmo_run),
    .expired(tmo_expired)
  );

  rmac_par #(.W(DATA_W)) u_par (
    .data(rm_rdata),
    .par (rm_rpar),
    .err (par_err)
  );

  // address and word capture, read merge
  always_comb begin
    addr_d = addr_q;
    word_d = word_q;
    if (accept) begin
      addr_d = {addr_hi, addr_lo[HOST_W-1 -: LO_BITS]};
      word_d = {wd0, wd1, wd2[HOST_W-1 -: TAIL_W]};
    end else if (rd_take) begin
      word_d = (op == OP_RMW) ? (rm_rdata | word_q) : rm_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      word_q <= '0;
    end else begin
      addr_q <= addr_d;
      word_q <= word_d;
    end
  end

  assign rm_addr   = addr_q;
  assign rm_wdata  = word_q;
  assign rm_fetch  = ((st == ST_ISSUE) && (op != OP_STORE)) || (st == ST_ABORT_F);
  assign rm_store  = (st == ST_ISSUE) && (op != OP_FETCH);
  assign rm_wvalid = ((st == ST_ISSUE) && (op == OP_STORE)) || (st == ST_WB);
  assign rm_reset  = (st == ST_ABORT_R);
  assign busy      = (st != ST_IDLE);
  assign done      = (st == ST_FINISH);

  assign rd0 = word_q[DATA_W-1 -: HOST_W];
  assign rd1 = word_q[DATA_W-HOST_W-1 -: HOST_W];
  assign rd2 = {word_q[TAIL_W-1:0], {PAD_W{1'b0}}};
endmodule

// File: rtl/rmac_chk.sv
module rmac_chk
  import rmac_pkg::*;
#(
  parameter int DATA_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [2:0]        opcode,
  input logic              rm_busy,
  input logic              busy,
  input logic              done,
  input logic [3:0]        err_code,
  input logic              rm_fetch,
  input logic              rm_store,
  input logic              rm_wvalid,
  input logic              rm_reset,
  input logic              rm_rvalid,
  input logic [DATA_W-1:0] rm_rdata,
  input logic              rm_rpar,
  input ctl_st_t           st
);
  // R8
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && rm_busy) |=> (done && err_code[2] && !rm_fetch && !rm_store && !rm_wvalid));

  // R9
  unimp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (opcode > 3'd2)) |=> (done && err_code[3] && !rm_fetch && !rm_store));

  // R6
  parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_WAIT_RD) && rm_rvalid && !(^{rm_rdata, rm_rpar})) |=> err_code[0]);

  // R12
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R12
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(rm_fetch || rm_store || rm_wvalid || rm_reset));

  // R10
  reset_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rm_reset |-> !(rm_fetch || rm_store || rm_wvalid));

  // R5
  rmw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_store && !rm_wvalid) |-> rm_fetch);
endmodule

bind rmac_top rmac_chk #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .opcode   (opcode),
  .rm_busy  (rm_busy),
  .busy     (busy),
  .done     (done),
  .err_code (err_code),
  .rm_fetch (rm_fetch),
  .rm_store (rm_store),
  .rm_wvalid(rm_wvalid),
  .rm_reset (rm_reset),
  .rm_rvalid(rm_rvalid),
  .rm_rdata (rm_rdata),
  .rm_rpar  (rm_rpar),
  .st       (st)
);

// File: tb/rmac_top_tb_top.sv
`timescale 1ns/1ps
module rmac_top_tb_top;
  localparam int TMO = 30;
  localparam int LAT = 3;
  localparam int NV  = 11;

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] hi, lo, w0, w1, w2;
    logic [39:0] pre;
    logic        flip, stall, bsy;
    logic [3:0]  err;
    logic        chk_rd;
    logic [39:0] rd;
    logic [39:0] mem_exp;
    logic [1:0]  nf, nr, nw;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{3'd0, 16'hABCD, 16'h5FFF, 16'h0, 16'h0, 16'h0, 40'h123456789A, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 40'h123456789A, 40'h123456789A, 2'd1, 2'd0, 2'd0},
    '{3'd1, 16'h1234, 16'h7000, 16'hDEAD, 16'hBEEF, 16'hA53C, 40'h0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 40'h0, 40'hDEADBEEFA5, 2'd0, 2'd0, 2'd1},
    '{3'd2, 16'h0F00, 16'h9ABC, 16'h0F0F, 16'h1234, 16'h8000, 40'hF0F0000001, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 40'hFFFF123481, 40'hFFFF123481, 2'd1, 2'd0, 2'd1},
    '{3'd0, 16'h0002, 16'h2000, 16'h0, 16'h0, 16'h0, 40'h0000000001, 1'b1, 1'b0, 1'b0, 4'd1, 1'b1, 40'h0000000001, 40'h0000000001, 2'd1, 2'd0, 2'd0},
    '{3'd2, 16'h0003, 16'h3000, 16'h0001, 16'h0000, 16'h0200, 40'h0000000010, 1'b1, 1'b0, 1'b0, 4'd1, 1'b1, 40'h0001000012, 40'h0001000012, 2'd1, 2'd0, 2'd1},
    '{3'd0, 16'h0005, 16'h5000, 16'h0, 16'h0, 16'h0, 40'h5555555555, 1'b0, 1'b0, 1'b1, 4'd4, 1'b0, 40'h0, 40'h5555555555, 2'd0, 2'd0, 2'd0},
    '{3'd5, 16'h0006, 16'h6000, 16'h1, 16'h1, 16'h1, 40'h6666666666, 1'b0, 1'b0, 1'b0, 4'd8, 1'b0, 40'h0, 40'h6666666666, 2'd0, 2'd0, 2'd0},
    '{3'd7, 16'h0008, 16'h8000, 16'h1, 16'h1, 16'h1, 40'h8888888888, 1'b0, 1'b0, 1'b1, 4'd12, 1'b0, 40'h0, 40'h8888888888, 2'd0, 2'd0, 2'd0},
    '{3'd0, 16'h000A, 16'hA000, 16'h0, 16'h0, 16'h0, 40'hAAAAAAAAAA, 1'b0, 1'b1, 1'b0, 4'd2, 1'b0, 40'h0, 40'hAAAAAAAAAA, 2'd2, 2'd1, 2'd0},
    '{3'd1, 16'h000B, 16'hB000, 16'hDEAD, 16'hBEEF, 16'hA500, 40'hBBBBBBBBBB, 1'b0, 1'b1, 1'b0, 4'd2, 1'b0, 40'h0, 40'hDEADBEEFA5, 2'd0, 2'd1, 2'd1},
    '{3'd2, 16'h000C, 16'hC000, 16'hFFFF, 16'hFFFF, 16'hFF00, 40'hCCCCCCCCCC, 1'b0, 1'b1, 1'b0, 4'd2, 1'b0, 40'h0, 40'hCCCCCCCCCC, 2'd2, 2'd1, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  opcode;
  logic [15:0] addr_hi, addr_lo, wd0, wd1, wd2;
  logic        busy, done;
  logic [3:0]  err_code;
  logic [15:0] rd0, rd1, rd2;
  logic [19:0] rm_addr;
  logic        rm_fetch, rm_store, rm_wvalid, rm_reset;
  logic [39:0] rm_wdata;
  logic        rm_busy;
  logic        rm_rvalid = 1'b0;
  logic [39:0] rm_rdata  = '0;
  logic        rm_rpar   = 1'b0;
  logic        rm_wdone  = 1'b0;

  always #2.5 clk = ~clk;

  rmac_top #(.TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .addr_hi(addr_hi), .addr_lo(addr_lo), .wd0(wd0), .wd1(wd1), .wd2(wd2),
    .busy(busy), .done(done), .err_code(err_code),
    .rd0(rd0), .rd1(rd1), .rd2(rd2),
    .rm_addr(rm_addr), .rm_fetch(rm_fetch), .rm_store(rm_store),
    .rm_wvalid(rm_wvalid), .rm_wdata(rm_wdata), .rm_reset(rm_reset),
    .rm_busy(rm_busy), .rm_rvalid(rm_rvalid), .rm_rdata(rm_rdata),
    .rm_rpar(rm_rpar), .rm_wdone(rm_wdone)
  );

  // remote memory model, acts on falling edges
  logic [39:0] mem [16];
  logic        stall, flip;
  int          n_fetch, n_reset, n_wr, rd_cnt, wr_cnt;
  logic [3:0]  ridx;
  logic [19:0] last_addr;

  always @(negedge clk) begin
    rm_rvalid <= 1'b0;
    rm_wdone  <= 1'b0;
    if (!rst_n) begin
      rd_cnt = 0;
      wr_cnt = 0;
    end else begin
      if (rd_cnt > 0) begin
        rd_cnt = rd_cnt - 1;
        if (rd_cnt == 0 && !stall) begin
          rm_rvalid <= 1'b1;
          rm_rdata  <= mem[ridx];
          rm_rpar   <= (~^mem[ridx]) ^ flip;
        end
      end
      if (wr_cnt > 0) begin
        wr_cnt = wr_cnt - 1;
        if (wr_cnt == 0 && !stall) rm_wdone <= 1'b1;
      end
      if (rm_reset) begin
        n_reset = n_reset + 1;
        rd_cnt = 0;
        wr_cnt = 0;
      end
      if (rm_fetch) begin
        n_fetch = n_fetch + 1;
        last_addr = rm_addr;
        ridx = rm_addr[3:0];
        rd_cnt = LAT;
      end
      if (rm_wvalid) begin
        n_wr = n_wr + 1;
        last_addr = rm_addr;
        mem[rm_addr[3:0]] = rm_wdata;
        wr_cnt = LAT;
      end
    end
  end

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic string tag_of(input int i);
    case (i)
      0: tag_of = "R3";
      1: tag_of = "R4";
      2: tag_of = "R5";
      3: tag_of = "R6";
      4: tag_of = "R7";
      5: tag_of = "R8";
      6, 7: tag_of = "R9";
      8, 10: tag_of = "R11";
      default: tag_of = "R10";
    endcase
  endfunction

  task automatic prep(input int idx, input logic [39:0] pre);
    @(posedge clk); #1;
    n_fetch = 0; n_reset = 0; n_wr = 0;
    mem[idx] = pre;
  endtask

  // issue a request and wait for done; cycles counted in falling edges
  task automatic run_op(input logic [2:0] op, input logic [15:0] hi, lo, a, b, c, output int cyc);
    @(negedge clk);
    start = 1'b1; opcode = op; addr_hi = hi; addr_lo = lo; wd0 = a; wd1 = b; wd2 = c;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end

  initial begin
    int cyc;
    logic [39:0] got;
    rst_n = 1'b0; start = 1'b0; opcode = '0; rm_busy = 1'b0;
    addr_hi = '0; addr_lo = '0; wd0 = '0; wd1 = '0; wd2 = '0;
    stall = 1'b0; flip = 1'b0; ridx = '0; last_addr = '0;
    n_fetch = 0; n_reset = 0; n_wr = 0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    // R13 reset state
    chk("R13", "busy", busy, 0);
    chk("R13", "done", done, 0);
    chk("R13", "err_code", err_code, 0);
    chk("R13", "rd words", {rd0, rd1, rd2}, 0);
    chk("R13", "strobes", {rm_fetch, rm_store, rm_wvalid, rm_reset}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      prep(int'(TBL[i].lo[15:12]), TBL[i].pre);
      stall = TBL[i].stall; flip = TBL[i].flip; rm_busy = TBL[i].bsy;
      run_op(TBL[i].op, TBL[i].hi, TBL[i].lo, TBL[i].w0, TBL[i].w1, TBL[i].w2, cyc);
      rm_busy = 1'b0;
      chk(tag_of(i), $sformatf("vec %0d done seen", i), done, 1);
      chk(tag_of(i), $sformatf("vec %0d err_code", i), err_code, TBL[i].err);
      if (TBL[i].chk_rd) begin
        got = {rd0, rd1, rd2[15:8]};
        chk("R2", $sformatf("vec %0d read word", i), got, TBL[i].rd);
        chk("R2", $sformatf("vec %0d rd2 low byte", i), rd2[7:0], 0);
      end
      chk(tag_of(i), $sformatf("vec %0d fetch strobes", i), n_fetch, TBL[i].nf);
      chk(tag_of(i), $sformatf("vec %0d reset strobes", i), n_reset, TBL[i].nr);
      chk(tag_of(i), $sformatf("vec %0d write strobes", i), n_wr, TBL[i].nw);
      if (TBL[i].nf + TBL[i].nw > 0)
        chk("R1", $sformatf("vec %0d remote address", i), last_addr, {TBL[i].hi, TBL[i].lo[15:12]});
      if (TBL[i].err[1]) begin
        chk("R10", $sformatf("vec %0d timeout not early", i), cyc >= TMO, 1);
        chk("R10", $sformatf("vec %0d timeout not late", i), cyc <= TMO + 6, 1);
      end
      if (TBL[i].err[2] || TBL[i].err[3])
        chk("R8", $sformatf("vec %0d reject latency", i), cyc, 1);
      @(negedge clk);
      chk("R12", $sformatf("vec %0d done single pulse", i), {done, busy}, 0);
      @(negedge clk);
      chk("R12", $sformatf("vec %0d err held", i), err_code, TBL[i].err);
      chk(tag_of(i), $sformatf("vec %0d remote word", i), mem[TBL[i].lo[15:12]], TBL[i].mem_exp);
      stall = 1'b0; flip = 1'b0;
    end

    // R12: start while busy is ignored
    prep(1, 40'h0102030405);
    @(negedge clk);
    start = 1'b1; opcode = 3'd0; addr_hi = 16'h0; addr_lo = 16'h1000;
    @(negedge clk);
    start = 1'b1; opcode = 3'd1; wd0 = 16'hFFFF; wd1 = 16'hFFFF; wd2 = 16'hFF00;
    @(negedge clk);
    start = 1'b0;
    chk("R12", "busy mid operation", busy, 1);
    cyc = 0;
    while (!done && cyc < 100) begin @(negedge clk); cyc++; end
    chk("R12", "ignored start err", err_code, 0);
    chk("R12", "ignored start no write", n_wr, 0);
    chk("R12", "ignored start one fetch", n_fetch, 1);
    chk("R12", "ignored start fetched word", {rd0, rd1, rd2[15:8]}, 40'h0102030405);
    @(negedge clk);
    chk("R12", "ignored start memory kept", mem[1], 40'h0102030405);

    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule